// File: doc/BRIEF.md
# CAN-FD Transmit Descriptor Ring Writer

This block takes complete CAN or CAN-FD messages from a valid/ready stream and stores each one in a circular transmit buffer. The buffer is divided into 16-byte descriptors. A message takes one 64-bit header doubleword, followed by zero to eight payload doublewords. The block writes one doubleword per clock through a plain synchronous memory write port. When a batch is complete, it publishes the new write offset to the consumer that fetches descriptors from the ring.

The producer marks the final message of a batch with a last flag. The block converts each byte length into a 4-bit data length code. A length that cannot be encoded is dropped and never written. If the dropped message is the first one of its batch, it raises an invalid-argument pulse. If messages of the batch were already written, it publishes them and raises a truncation pulse.

Before a message is accepted, the block checks that the ring has enough free descriptors for it. The number needed depends on the message length. The read offset comes from the consumer, and the ring size is an input.

Top module: `cantx_desc_writer`

## Requirements
- R1: Lengths 0 to 8 encode as data length codes 0 to 8. For frames with FD option bit 1 set, lengths 12, 16, 20, 24, 32, 48 and 64 encode as codes 9, 10, 11, 12, 13, 14 and 15.
- R2: The following lengths are illegal:
  - any length above 64;
  - an FD length above 8 that is not listed in R1;
  - any length above 8 when FD option bit 1 is clear.

  An illegal message is accepted from the stream and dropped, and no memory write occurs.
- R3: A frame with FD option bit 1 clear occupies one descriptor. A frame with that bit set occupies 1 + ((len + 7) >> 4) descriptors. The working write offset advances by 16 bytes per descriptor and wraps by subtracting the ring size.
- R4: A legal message is accepted only when the free descriptor count is at least its need. Free descriptors equal gap/16 - 1, where gap is rd - wr if rd > wr and size - wr + rd otherwise. When the need is not met, msg_ready stays low.
- R5: The upper 32 bits of the header doubleword hold the length code in bits 63:60 and the two FD option bits in bits 58:57. All other bits of that half are zero.
- R6: The lower 32 bits of the header hold the extended flag in bit 31 and the remote flag in bit 30. An extended identifier occupies bits 29:0. A standard frame places the low 12 identifier bits in bits 29:18 and leaves bits 17:0 at zero.
- R7: ceil(len/8) payload doublewords follow the header at byte offsets +8, +16 and so on. Payload byte i sits in bits 8*(i%8)+7 : 8*(i%8) of doubleword i/8. Each write address wraps to 0 on reaching the ring size.
- R8: wr_off changes only when a message flagged last finishes or when a batch is truncated. Either event sets tx_en, which then stays set.
- R9: An illegal message arriving while the current batch has no written message pulses err_inval for one cycle. Otherwise it pulses err_cut for one cycle, publishes the written messages, and starts a new batch.
- R10: A legal message is written as one doubleword per cycle, header first, starting the cycle after acceptance. msg_ready is low during this time. Publication is visible the cycle after the last doubleword.
- R11: msg_count increments by one for each message written to the ring.
- R12: After reset, wr_off, tx_en, msg_count, err_inval, err_cut and mem_we are zero, and the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Message accepted this cycle if valid |
| msg_id | input | 30 | Identifier (standard frames use bits 11:0) |
| msg_ext | input | 1 | Extended identifier frame |
| msg_rtr | input | 1 | Remote request |
| msg_fdopt | input | 2 | Bit 1: FD frame; bit 0: bit-rate switch |
| msg_len | input | 7 | Payload length in bytes |
| msg_last | input | 1 | Final message of a batch |
| msg_data | input | 512 | Payload, byte i in bits 8i+7:8i |
| rd_off | input | OFF_W | Consumer read byte offset |
| buf_size | input | OFF_W | Ring size in bytes, multiple of 16 |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | OFF_W | Byte offset of the doubleword written |
| mem_wdata | output | 64 | Doubleword written |
| wr_off | output | OFF_W | Published write byte offset |
| tx_en | output | 1 | Transmit enable, set on first publication |
| err_inval | output | 1 | Illegal length at batch start |
| err_cut | output | 1 | Illegal length truncated a batch |
| msg_count | output | CNT_W | Messages written |

## Verification
The bench builds the block with its default OFF_W of 12 and CNT_W of 16. It drives buf_size with a 128-byte ring of eight descriptors. Because the ring is this small, a single 64-byte FD frame fills most of it. A following frame forces a payload doubleword to wrap to offset 0 and the write offset to wrap past the ring end. Moving rd_off then brings the full-ring stall and its release within reach in a few messages.

// File: rtl/cantx_pkg.sv
package cantx_pkg;
  localparam int ID_W    = 30;
  localparam int LEN_W   = 7;
  localparam int PAY_W   = 512;
  localparam int DW_W    = 64;
  localparam int DESC_B  = 16;
  localparam int DW_B    = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_WRITE = 1'b1} wr_state_e;
endpackage

// File: rtl/cantx_len_code.sv
module cantx_len_code
  import cantx_pkg::*;
(
  input  logic [LEN_W-1:0] len,
  input  logic             fd,
  output logic [3:0]       dlc,
  output logic             bad,
  output logic [2:0]       n_desc,
  output logic [3:0]       n_dw
);
  always_comb begin
    bad = 1'b0;
    dlc = len[3:0];
    if (len > 7'd8) begin
      if (!fd) begin
        bad = 1'b1;
      end else begin
        case (len)
          7'd12:   dlc = 4'h9;
          7'd16:   dlc = 4'hA;
          7'd20:   dlc = 4'hB;
          7'd24:   dlc = 4'hC;
          7'd32:   dlc = 4'hD;
          7'd48:   dlc = 4'hE;
          7'd64:   dlc = 4'hF;
          default: bad = 1'b1;
        endcase
      end
    end
  end

  // doublewords = ceil(len/8); descriptors for FD = 1 + floor(ceil(len/8)/2)
  assign n_dw   = len[6:3] + {3'b0, (len[2:0] != 3'b0)};
  assign n_desc = fd ? (3'd1 + n_dw[3:1]) : 3'd1;
endmodule

// File: rtl/cantx_ring_space.sv
module cantx_ring_space #(
  parameter int OFF_W = 12
) (
  input  logic [OFF_W-1:0] wr,
  input  logic [OFF_W-1:0] rd,
  input  logic [OFF_W-1:0] size,
  output logic [OFF_W-4:0] free_desc
);
  logic [OFF_W:0]   gap;
  logic [OFF_W-4:0] blocks;

  always_comb begin
    if (rd > wr) gap = {1'b0, rd} - {1'b0, wr};
    else         gap = {1'b0, size} - {1'b0, wr} + {1'b0, rd};
  end

  assign blocks    = gap[OFF_W:4];
  // one descriptor is held back so a full ring never looks empty
  assign free_desc = (blocks == '0) ? '0 : blocks - 1'b1;
endmodule

// File: rtl/cantx_desc_writer.sv
module cantx_desc_writer
  import cantx_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [ID_W-1:0]    msg_id,
  input  logic               msg_ext,
  input  logic               msg_rtr,
  input  logic [1:0]         msg_fdopt,
  input  logic [LEN_W-1:0]   msg_len,
  input  logic               msg_last,
  input  logic [PAY_W-1:0]   msg_data,
  input  logic [OFF_W-1:0]   rd_off,
  input  logic [OFF_W-1:0]   buf_size,
  output logic               mem_we,
  output logic [OFF_W-1:0]   mem_addr,
  output logic [DW_W-1:0]    mem_wdata,
  output logic [OFF_W-1:0]   wr_off,
  output logic               tx_en,
  output logic               err_inval,
  output logic               err_cut,
  output logic [CNT_W-1:0]   msg_count
);
  localparam logic [OFF_W:0] STEP_DW = (OFF_W+1)'(DW_B);

  wr_state_e         state_q, state_d;
  logic [3:0]        idx_q, idx_d, nwords_q, nwords_d;
  logic [OFF_W-1:0]  addr_q, addr_d, wp_q, wp_d, nwp_q, nwp_d;
  logic [OFF_W-1:0]  wr_off_q, wr_off_d;
  logic [DW_W-1:0]   head_q, head_d;
  logic [PAY_W-1:0]  data_q;
  logic              data_en;
  logic              last_q, last_d, batch_q, batch_d;
  logic              tx_en_q, tx_en_d, inval_q, inval_d, cut_q, cut_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [3:0]        dlc, n_dw;
  logic              len_bad;
  logic [2:0]        n_desc;
  logic [OFF_W-4:0]  free_desc;
  logic              fits, accept;
  logic [OFF_W:0]    sum, size_x, addr_inc;
  logic [OFF_W-1:0]  nwp_calc, addr_next;
  logic [31:0]       hw0, hw1;
  logic [2:0]        sel;

  cantx_len_code u_len (
    .len(msg_len), .fd(msg_fdopt[1]), .dlc(dlc), .bad(len_bad),
    .n_desc(n_desc), .n_dw(n_dw)
  );

  cantx_ring_space #(.OFF_W(OFF_W)) u_space (
    .wr(wp_q), .rd(rd_off), .size(buf_size), .free_desc(free_desc)
  );

  // ---------------- combinational datapath ----------------
  assign fits      = free_desc >= {{(OFF_W-6){1'b0}}, n_desc};
  assign msg_ready = (state_q == ST_IDLE) && (len_bad || fits);
  assign accept    = msg_valid && msg_ready;

  assign size_x   = {1'b0, buf_size};
  assign sum      = {1'b0, wp_q} + {{(OFF_W-6){1'b0}}, n_desc, 4'b0};
  assign nwp_calc = (sum >= size_x) ? OFF_W'(sum - size_x) : sum[OFF_W-1:0];
  assign addr_inc = {1'b0, addr_q} + STEP_DW;
  assign addr_next = (addr_inc >= size_x) ? '0 : addr_inc[OFF_W-1:0];

  assign hw0 = msg_ext ? {1'b1, msg_rtr, msg_id}
                       : {1'b0, msg_rtr, msg_id[11:0], 18'b0};
  assign hw1 = {dlc, 1'b0, msg_fdopt, 25'b0};

  assign sel       = 3'(idx_q - 4'd1);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = (idx_q == 4'd0) ? head_q : data_q[{sel, 6'b0} +: DW_W];

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;  idx_d   = idx_q;   nwords_d = nwords_q;
    addr_d   = addr_q;   wp_d    = wp_q;    nwp_d    = nwp_q;
    wr_off_d = wr_off_q; head_d  = head_q;  last_d   = last_q;
    batch_d  = batch_q;  tx_en_d = tx_en_q; cnt_d    = cnt_q;
    inval_d  = 1'b0;     cut_d   = 1'b0;    data_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (len_bad) begin
            inval_d = !batch_q;
            cut_d   = batch_q;
            if (batch_q) begin
              wr_off_d = wp_q;
              tx_en_d  = 1'b1;
            end
            batch_d = 1'b0;
          end else begin
            state_d  = ST_WRITE;
            idx_d    = 4'd0;
            nwords_d = 4'd1 + n_dw;
            addr_d   = wp_q;
            nwp_d    = nwp_calc;
            head_d   = {hw1, hw0};
            last_d   = msg_last;
            data_en  = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        addr_d = addr_next;
        idx_d  = idx_q + 4'd1;
        if (idx_q == nwords_q - 4'd1) begin
          state_d = ST_IDLE;
          wp_d    = nwp_q;
          cnt_d   = cnt_q + 1'b1;
          if (last_q) begin
            wr_off_d = nwp_q;
            tx_en_d  = 1'b1;
            batch_d  = 1'b0;
          end else begin
            batch_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; idx_q <= '0;  nwords_q <= '0;
      addr_q  <= '0;      wp_q  <= '0;  nwp_q    <= '0;
      wr_off_q <= '0;     head_q <= '0; last_q   <= 1'b0;
      batch_q <= 1'b0;    tx_en_q <= 1'b0; cnt_q <= '0;
      inval_q <= 1'b0;    cut_q  <= 1'b0;
    end else begin
      state_q <= state_d; idx_q <= idx_d; nwords_q <= nwords_d;
      addr_q  <= addr_d;  wp_q  <= wp_d;  nwp_q    <= nwp_d;
      wr_off_q <= wr_off_d; head_q <= head_d; last_q <= last_d;
      batch_q <= batch_d; tx_en_q <= tx_en_d; cnt_q <= cnt_d;
      inval_q <= inval_d; cut_q  <= cut_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= msg_data;
  end

  assign wr_off    = wr_off_q;
  assign tx_en     = tx_en_q;
  assign err_inval = inval_q;
  assign err_cut   = cut_q;
  assign msg_count = cnt_q;

  // ---------------- assertions ----------------
  a_r7_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < buf_size) && (mem_addr[2:0] == 3'b0));

  a_r3_desc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q[3:0] == 4'b0) && (wr_off[3:0] == 4'b0));

  a_r4_keep_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_size != '0) |-> ({1'b0, free_desc, 4'b0} < {1'b0, buf_size}));

  a_r8_publish_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_off) |-> tx_en);

  a_r9_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_inval && err_cut));

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msg_count) |-> (msg_count == $past(msg_count) + 1'b1));
endmodule

// File: tb/tb_cantx_desc_writer.sv
module tb_cantx_desc_writer;
  localparam int OFF_W = 12;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic msg_valid = 1'b0, msg_ready;
  logic [29:0] msg_id = '0;
  logic msg_ext = 1'b0, msg_rtr = 1'b0, msg_last = 1'b0;
  logic [1:0] msg_fdopt = '0;
  logic [6:0] msg_len = '0;
  logic [511:0] msg_data = '0;
  logic [OFF_W-1:0] rd_off = '0, buf_size = 12'd128;
  logic mem_we, tx_en, err_inval, err_cut;
  logic [OFF_W-1:0] mem_addr, wr_off;
  logic [63:0] mem_wdata;
  logic [CNT_W-1:0] msg_count;

  cantx_desc_writer #(.OFF_W(OFF_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_id(msg_id), .msg_ext(msg_ext), .msg_rtr(msg_rtr),
    .msg_fdopt(msg_fdopt), .msg_len(msg_len), .msg_last(msg_last),
    .msg_data(msg_data), .rd_off(rd_off), .buf_size(buf_size),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_off(wr_off), .tx_en(tx_en), .err_inval(err_inval),
    .err_cut(err_cut), .msg_count(msg_count)
  );

  logic [63:0] mem [0:15];
  int wr_cnt = 0, inval_cnt = 0, cut_cnt = 0;
  int n_chk = 0, n_fail = 0;

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr[6:3]] <= mem_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  always @(negedge clk) begin
    if (err_inval) inval_cnt++;
    if (err_cut)   cut_cnt++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pattern(input logic [7:0] seed);
    logic [511:0] p;
    for (int i = 0; i < 64; i++) p[8*i +: 8] = seed + 8'(i * 3);
    return p;
  endfunction

  function automatic logic [63:0] head(input logic ext, input logic rtr,
      input logic [29:0] id, input logic [1:0] fdo, input logic [3:0] code);
    logic [31:0] w0;
    w0 = ext ? {1'b1, rtr, id} : {1'b0, rtr, id[11:0], 18'b0};
    return {code, 1'b0, fdo, 25'b0, w0};
  endfunction

  task automatic offer(input logic [29:0] id, input logic ext, input logic rtr,
      input logic [1:0] fdo, input logic [6:0] len, input logic last,
      input logic [7:0] seed);
    @(negedge clk);
    msg_id = id; msg_ext = ext; msg_rtr = rtr; msg_fdopt = fdo;
    msg_len = len; msg_last = last; msg_data = pattern(seed);
    msg_valid = 1'b1;
    #1;
    while (!msg_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    msg_valid = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 wr_off", 64'(wr_off), 64'd0);
    chk("R12 tx_en", 64'(tx_en), 64'd0);
    chk("R12 count", 64'(msg_count), 64'd0);
    chk("R12 mem_we", 64'(mem_we), 64'd0);
    chk("R12 errors", 64'({err_inval, err_cut}), 64'd0);
    chk("R12 ready", 64'(msg_ready), 64'd1);
  endtask

  task automatic t_classic;
    logic [511:0] p;
    int w0;
    p = pattern(8'h10); w0 = wr_cnt;
    offer(30'h5A3, 1'b0, 1'b0, 2'b00, 7'd8, 1'b1, 8'h10);
    chk("R6 R5 R1 std header", mem[0], head(1'b0, 1'b0, 30'h5A3, 2'b00, 4'd8));
    chk("R7 payload dw0", mem[1], p[63:0]);
    chk("R10 words written", 64'(wr_cnt - w0), 64'd2);
    chk("R3 R8 wr_off", 64'(wr_off), 64'd16);
    chk("R8 tx_en", 64'(tx_en), 64'd1);
    w0 = wr_cnt;
    offer(30'h1ABCDEF0, 1'b1, 1'b1, 2'b00, 7'd0, 1'b1, 8'h20);
    chk("R6 ext rtr header", mem[2], head(1'b1, 1'b1, 30'h1ABCDEF0, 2'b00, 4'd0));
    chk("R7 zero length one word", 64'(wr_cnt - w0), 64'd1);
    chk("R3 wr_off", 64'(wr_off), 64'd32);
  endtask

  task automatic t_fd_wrap;
    logic [511:0] p;
    int w0;
    p = pattern(8'h40); w0 = wr_cnt;
    offer(30'h7FF, 1'b0, 1'b0, 2'b11, 7'd64, 1'b1, 8'h40);
    chk("R1 R5 fd64 header", mem[4], head(1'b0, 1'b0, 30'h7FF, 2'b11, 4'hF));
    chk("R7 fd64 first dw", mem[5], p[63:0]);
    chk("R7 fd64 last dw", mem[12], p[511:448]);
    chk("R10 fd64 words", 64'(wr_cnt - w0), 64'd9);
    chk("R3 fd64 five desc", 64'(wr_off), 64'd112);
    rd_off = 12'd112;
    p = pattern(8'h80);
    offer(30'h123, 1'b0, 1'b0, 2'b10, 7'd12, 1'b1, 8'h80);
    chk("R1 fd12 header", mem[14], head(1'b0, 1'b0, 30'h123, 2'b10, 4'h9));
    chk("R7 fd12 dw0", mem[15], p[63:0]);
    chk("R7 fd12 wrapped dw1", mem[0], p[127:64]);
    chk("R3 wr_off wraps", 64'(wr_off), 64'd16);
  endtask

  task automatic t_illegal;
    int w0;
    w0 = wr_cnt;
    offer(30'h1, 1'b0, 1'b0, 2'b10, 7'd28, 1'b1, 8'h01);
    chk("R9 fd28 inval", 64'(inval_cnt), 64'd1);
    offer(30'h2, 1'b0, 1'b0, 2'b00, 7'd12, 1'b1, 8'h02);
    chk("R2 classic12 inval", 64'(inval_cnt), 64'd2);
    offer(30'h3, 1'b0, 1'b0, 2'b10, 7'd65, 1'b1, 8'h03);
    chk("R2 len65 inval", 64'(inval_cnt), 64'd3);
    chk("R2 nothing written", 64'(wr_cnt - w0), 64'd0);
    chk("R2 wr_off unchanged", 64'(wr_off), 64'd16);
    chk("R9 no cut", 64'(cut_cnt), 64'd0);
  endtask

  task automatic t_batch_cut;
    offer(30'h44, 1'b0, 1'b0, 2'b00, 7'd4, 1'b0, 8'h50);
    chk("R8 not published mid-batch", 64'(wr_off), 64'd16);
    offer(30'h45, 1'b0, 1'b0, 2'b10, 7'd36, 1'b1, 8'h51);
    chk("R9 cut pulse", 64'(cut_cnt), 64'd1);
    chk("R9 cut no inval", 64'(inval_cnt), 64'd3);
    chk("R9 cut publishes", 64'(wr_off), 64'd32);
  endtask

  task automatic t_full;
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    msg_id = 30'h66; msg_ext = 1'b0; msg_rtr = 1'b0; msg_fdopt = 2'b10;
    msg_len = 7'd64; msg_last = 1'b1; msg_data = pattern(8'h90);
    msg_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 ready low when four free", 64'(msg_ready), 64'd0);
    chk("R4 no write while stalled", 64'(wr_cnt - w0), 64'd0);
    rd_off = 12'd0;
    #1;
    while (!msg_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    msg_valid = 1'b0;
    chk("R10 ready low while writing", 64'(msg_ready), 64'd0);
    repeat (11) @(negedge clk);
    chk("R4 accepted after release", 64'(wr_cnt - w0), 64'd9);
    chk("R3 wr_off", 64'(wr_off), 64'd112);
    chk("R11 message count", 64'(msg_count), 64'd6);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_classic();
    t_fd_wrap();
    t_illegal();
    t_batch_cut();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule